// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs one read or write transfer on an external memory bus for each request from the core. A transfer opens with a one-clock address latch strobe. An optional idle clock can follow it. Then the active-low read or write command is driven. The command is held for a programmed number of fixed wait states. After those, every clock is a point where an active-low READY input is sampled. READY sampled high adds one more clock; READY sampled low ends the transfer. The last command clock carries a one-clock done pulse back to the core.

READY can be taken in two ways. In synchronous mode it passes through one register. In asynchronous mode it passes through a two-stage synchronizer, which costs one extra clock. A READY that never arrives is cut off by a timeout, which raises an error pulse. After each transfer a recovery gap may follow, and its length depends on the bus mode. A multiplexed bus adds one clock, and an optional trailing wait adds one more. A request that arrives while a transfer or the recovery gap is running is held in a single slot. It starts as soon as the gap ends. The block also drives a clock-output enable for the bus.

Top module: `ebus_cycle_seq`

## Requirements
- R1: While reset is low and after its release with no request, `ale_o` is 0, `rd_n_o` and `wr_n_o` are 1, and `done_o` and `tmo_err_o` are 0.
- R2: `ale_o` is 1 for exactly one clock at the start of each transfer, and never in the same clock as an active command.
- R3: The command goes low 1 clock after the `ale_o` clock when `cfg_cmd_dly_i` is 0, and 2 clocks after it when `cfg_cmd_dly_i` is 1.
- R4: A transfer requested with `wr_i`=0 drives only `rd_n_o` low, and one requested with `wr_i`=1 drives only `wr_n_o` low. The two are never low together.
- R5: With READY held low, the command lasts `cfg_ws_i`+1 clocks.
- R6: Synchronous mode (`cfg_async_i`=0): READY is held high and then driven low during command clock j, counted from 0. The command then lasts max(`cfg_ws_i`, j+1)+1 clocks.
- R7: Asynchronous mode (`cfg_async_i`=1): under the same stimulus as R6, the command lasts max(`cfg_ws_i`, j+2)+1 clocks.
- R8: `done_o` is 1 in exactly one clock per transfer. That clock is the last command clock, and the command is released in the next clock.
- R9: The next `ale_o` clock falls at least 1+G clocks after the `done_o` clock, and exactly that many when a request is waiting. G is 0 for a demultiplexed bus (`cfg_mux_i`=0) without a trailing wait (`cfg_trail_i`=0). G is 1 for a multiplexed bus alone or a demultiplexed bus with the trailing wait. G is 2 for a multiplexed bus with the trailing wait.
- R10: A single-clock request pulse that arrives during a transfer or its recovery gap is held. It starts a transfer on the first clock the R9 gap allows.
- R11: With READY stuck high, the transfer ends after `TIMEOUT_CYC` READY wait states, so the command lasts `cfg_ws_i`+1+`TIMEOUT_CYC` clocks. `tmo_err_o` pulses in the `done_o` clock and is 0 on a normal end.
- R12: `clkout_en_o` is 1 whenever synchronous mode is selected or a transfer or recovery gap is running. It is 0 when the block is idle in asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | One-clock transfer request pulse |
| wr_i | input | 1 | Direction of the request: 1 write, 0 read |
| cfg_ws_i | input | WS_W | Programmed fixed wait states |
| cfg_cmd_dly_i | input | 1 | Insert one idle clock between strobe and command |
| cfg_async_i | input | 1 | 1 selects the READY synchronizer path |
| cfg_mux_i | input | 1 | Multiplexed bus: one recovery clock after each transfer |
| cfg_trail_i | input | 1 | One extra trailing recovery clock |
| rdy_n_i | input | 1 | READY from the device, active low |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read command, active low |
| wr_n_o | output | 1 | Write command, active low |
| done_o | output | 1 | Transfer finished, one clock |
| tmo_err_o | output | 1 | Transfer ended by READY timeout |
| clkout_en_o | output | 1 | Clock-output enable for the bus |

## Verification
The properties assume that the configuration inputs stay constant from a request until the recovery gap ends. They also assume that requests come as one-clock pulses, with at most one outstanding beyond the transfer in progress. The bench changes configuration only after a transfer has fully drained. It pulses each request for a single clock. It moves READY only at the falling clock edge, so the synchronous path always sees a clean level. Reset is held with no request present, so the strobe and command properties start from an idle sequencer.

// File: rtl/ebc_pkg.sv
// Shared types for the external bus cycle sequencer.
// Assumes: recovery never exceeds two clocks, so a 2-bit count suffices.
package ebc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_DLY,
        ST_CMD,
        ST_REC
    } ebc_state_e;

    localparam int REC_W = 2;

    // Recovery clocks after a transfer, from bus mode and trailing-wait select.
    function automatic logic [REC_W-1:0] rec_len(input logic mux, input logic trail);
        logic [REC_W-1:0] n;
        n = REC_W'(0);
        if (mux)
            n = n + REC_W'(1);
        if (trail)
            n = n + REC_W'(1);
        return n;
    endfunction

endpackage

// File: rtl/ebc_rdy_sync.sv
// READY input conditioning. A chain of STAGES flops samples rdy_n_i.
// Synchronous mode uses the first stage only; asynchronous mode uses the
// last stage. Assumes STAGES >= 2. All stages reset to "not ready".
module ebc_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n_i,
    input  logic async_i,
    output logic rdy_n_o
);

    logic [STAGES-1:0] chain_q;

    // First stage: capture the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q[0] <= 1'b1;
        else
            chain_q[0] <= rdy_n_i;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Later stages: shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q[gi] <= 1'b1;
                else
                    chain_q[gi] <= chain_q[gi-1];
            end
        end
    endgenerate

    assign rdy_n_o = async_i ? chain_q[STAGES-1] : chain_q[0];

endmodule

// File: rtl/ebc_dncnt.sv
// Loadable down counter. Load has priority over decrement, and the count
// never wraps below zero. Assumes the caller decrements only when nonzero.
module ebc_dncnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Count register: load, or step down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (dec_i && (cnt_q != '0))
            cnt_q <= cnt_q - W'(1);
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ebc_req_hold.sv
// Single-slot holder for a request pulse that cannot start at once.
// take_i marks the clock in which the sequencer starts a transfer; the
// held request is consumed first, otherwise the live pulse is.
// Assumes at most one request beyond the one being started.
module ebc_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic wr_i,
    input  logic take_i,
    output logic avail_o,
    output logic start_wr_o
);

    logic pend_q;
    logic pend_wr_q;
    logic store;

    // Keep the live pulse unless it is the one being started right now.
    assign store = req_i && !(take_i && !pend_q);

    // Slot register: fill on a stored pulse, empty when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_wr_q <= 1'b0;
        end else begin
            pend_q <= store || (pend_q && !take_i);
            if (store)
                pend_wr_q <= wr_i;
        end
    end

    assign avail_o    = pend_q || req_i;
    assign start_wr_o = pend_q ? pend_wr_q : wr_i;

endmodule

// File: rtl/ebus_cycle_seq.sv
// External bus cycle sequencer: strobe, optional command delay, fixed wait
// states, READY-stretched command, then a mode-dependent recovery gap.
// Assumes configuration inputs are stable from request to end of recovery
// and that requests arrive as one-clock pulses.
module ebus_cycle_seq
    import ebc_pkg::*;
#(
    parameter int WS_W        = 4,
    parameter int TIMEOUT_CYC = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            wr_i,
    input  logic [WS_W-1:0] cfg_ws_i,
    input  logic            cfg_cmd_dly_i,
    input  logic            cfg_async_i,
    input  logic            cfg_mux_i,
    input  logic            cfg_trail_i,
    input  logic            rdy_n_i,
    output logic            ale_o,
    output logic            rd_n_o,
    output logic            wr_n_o,
    output logic            done_o,
    output logic            tmo_err_o,
    output logic            clkout_en_o
);

    localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

    ebc_state_e       state_q, state_d;
    logic             cur_wr_q;
    logic [TMO_W-1:0] tcnt_q;
    logic             rdy_use;
    logic             start_avail, start_wr, go_start;
    logic             ws_zero;
    logic [WS_W-1:0]  ws_cnt;
    logic [REC_W-1:0] rec_cnt, rec_n;
    logic             rec_zero, rec_last;
    logic             sample, tmo_hit, term;

    ebc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy_n_i (rdy_n_i),
        .async_i (cfg_async_i),
        .rdy_n_o (rdy_use)
    );

    ebc_req_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .wr_i       (wr_i),
        .take_i     (go_start),
        .avail_o    (start_avail),
        .start_wr_o (start_wr)
    );

    ebc_dncnt #(.W(WS_W)) u_ws (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i ((state_q == ST_ALE) || (state_q == ST_DLY)),
        .val_i  (cfg_ws_i),
        .dec_i  ((state_q == ST_CMD) && !ws_zero),
        .cnt_o  (ws_cnt),
        .zero_o (ws_zero)
    );

    ebc_dncnt #(.W(REC_W)) u_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (term),
        .val_i  (rec_n),
        .dec_i  (state_q == ST_REC),
        .cnt_o  (rec_cnt),
        .zero_o (rec_zero)
    );

    assign rec_n    = rec_len(cfg_mux_i, cfg_trail_i);
    assign rec_last = (rec_cnt == REC_W'(1)) && !rec_zero;
    assign sample   = (state_q == ST_CMD) && ws_zero;
    assign tmo_hit  = (tcnt_q == TMO_W'(TIMEOUT_CYC));
    assign term     = sample && (!rdy_use || tmo_hit);

    // Next-state selection for the transfer sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_avail) state_d = ST_ALE;
            ST_ALE:  state_d = cfg_cmd_dly_i ? ST_DLY : ST_CMD;
            ST_DLY:  state_d = ST_CMD;
            ST_CMD:
                if (term) begin
                    if (rec_n != REC_W'(0))
                        state_d = ST_REC;
                    else
                        state_d = start_avail ? ST_ALE : ST_IDLE;
                end
            ST_REC:
                if (rec_last)
                    state_d = start_avail ? ST_ALE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign go_start = (state_d == ST_ALE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Direction of the transfer being started.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_wr_q <= 1'b0;
        else if (go_start)
            cur_wr_q <= start_wr;
    end

    // READY wait-state count for the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt_q <= '0;
        else if (state_q == ST_ALE)
            tcnt_q <= '0;
        else if (sample && !term)
            tcnt_q <= tcnt_q + TMO_W'(1);
    end

    assign ale_o       = (state_q == ST_ALE);
    assign rd_n_o      = !((state_q == ST_CMD) && !cur_wr_q);
    assign wr_n_o      = !((state_q == ST_CMD) && cur_wr_q);
    assign done_o      = term;
    assign tmo_err_o   = term && rdy_use;
    assign clkout_en_o = !cfg_async_i || (state_q != ST_IDLE);

endmodule

// File: rtl/ebc_seq_chk.sv
// Property checker for ebus_cycle_seq, attached by bind below.
// Assumes configuration is held stable while a transfer runs.
module ebc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_mux_i,
    input logic ale_o,
    input logic rd_n_o,
    input logic wr_n_o,
    input logic done_o,
    input logic tmo_err_o,
    input logic clkout_en_o
);

    logic cmd_act;
    assign cmd_act = !(rd_n_o && wr_n_o);

    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    p_ale_no_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_o && cmd_act));

    p_cmd_after_ale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n_o) || $fell(wr_n_o)) |-> ($past(ale_o) || $past(ale_o, 2)));

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));

    p_done_in_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cmd_act);

    p_cmd_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !cmd_act);

    p_mux_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cfg_mux_i) |=> !ale_o);

    p_tmo_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err_o |-> done_o);

    p_clkout_in_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act || ale_o) |-> clkout_en_o);

endmodule

bind ebus_cycle_seq ebc_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mux_i   (cfg_mux_i),
    .ale_o       (ale_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o),
    .done_o      (done_o),
    .tmo_err_o   (tmo_err_o),
    .clkout_en_o (clkout_en_o)
);

// File: tb/sim_ebus_cycle_seq.sv
module sim_ebus_cycle_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [3:0] cfg_ws_i = 4'd0;
    logic       cfg_cmd_dly_i = 1'b0;
    logic       cfg_async_i = 1'b0;
    logic       cfg_mux_i = 1'b0;
    logic       cfg_trail_i = 1'b0;
    logic       rdy_n_i = 1'b0;
    logic       ale_o, rd_n_o, wr_n_o, done_o, tmo_err_o, clkout_en_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ebus_cycle_seq u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .wr_i          (wr_i),
        .cfg_ws_i      (cfg_ws_i),
        .cfg_cmd_dly_i (cfg_cmd_dly_i),
        .cfg_async_i   (cfg_async_i),
        .cfg_mux_i     (cfg_mux_i),
        .cfg_trail_i   (cfg_trail_i),
        .rdy_n_i       (rdy_n_i),
        .ale_o         (ale_o),
        .rd_n_o        (rd_n_o),
        .wr_n_o        (wr_n_o),
        .done_o        (done_o),
        .tmo_err_o     (tmo_err_o),
        .clkout_en_o   (clkout_en_o)
    );

    typedef struct packed {
        logic [3:0] ws;
        logic       dly;
        logic       asy;
        logic       mux;
        logic       trl;
        logic       wr;
        logic [8:0] len;
        logic [3:0] a2c;
        logic [3:0] gap;
    } vec_t;

    // ws, dly, async, mux, trail, wr -> command length, strobe-to-command, done-to-strobe
    localparam vec_t VECS [8] = '{
        '{4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd1,  4'd1, 4'd1},
        '{4'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'd4,  4'd1, 4'd2},
        '{4'd1,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'd2,  4'd2, 4'd3},
        '{4'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'd8,  4'd2, 4'd2},
        '{4'd15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd16, 4'd1, 4'd1},
        '{4'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 9'd3,  4'd2, 4'd3},
        '{4'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'd1,  4'd1, 4'd2},
        '{4'd5,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'd6,  4'd1, 4'd2}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // sec_mode: -1 no second request, 0 at first command clock, k>0 k clocks after done.
    // drop_at: clock offset from command start at which READY is driven low, -1 never.
    task automatic measure(input logic w, input int sec_mode, input int drop_at,
                           output int a2c, output int len, output int gap,
                           output logic ale_ok, output logic strobe_ok,
                           output logic done_ok, output logic tmo_seen);
        int t_ale, t_cmd, t_done, t_ale2, n_done, need, tail;
        logic cmd;
        t_ale = -1; t_cmd = -1; t_done = -1; t_ale2 = -1;
        n_done = 0; tail = -1; len = 0;
        ale_ok = 1'b1; strobe_ok = 1'b1; done_ok = 1'b1; tmo_seen = 1'b0;
        need = (sec_mode >= 0) ? 2 : 1;
        @(negedge clk);
        req_i = 1'b1;
        wr_i  = w;
        @(negedge clk);
        req_i = 1'b0;
        for (int t = 0; t < 700; t++) begin
            cmd = w ? !wr_n_o : !rd_n_o;
            if (w ? !rd_n_o : !wr_n_o) strobe_ok = 1'b0;
            if (ale_o && cmd) ale_ok = 1'b0;
            if (ale_o) begin
                if (t_ale < 0) t_ale = t;
                else if (t_ale2 < 0 && t_done >= 0) t_ale2 = t;
            end
            if (t_ale >= 0 && t == t_ale + 1 && ale_o) ale_ok = 1'b0;
            if (cmd && t_cmd < 0) t_cmd = t;
            if (cmd && t_done < 0) len++;
            if (t_done >= 0 && t == t_done + 1 && cmd) done_ok = 1'b0;
            if (done_o && !cmd) done_ok = 1'b0;
            if (done_o) begin
                n_done++;
                if (t_done < 0) begin
                    t_done = t;
                    tmo_seen = tmo_err_o;
                end
            end
            req_i = 1'b0;
            if (sec_mode == 0 && t == t_cmd) req_i = 1'b1;
            if (sec_mode > 0 && t_done >= 0 && t == t_done + sec_mode) req_i = 1'b1;
            if (drop_at >= 0 && t_cmd >= 0 && t == t_cmd + drop_at) rdy_n_i = 1'b0;
            if (n_done == need && tail < 0) tail = 5;
            if (tail == 0) break;
            if (tail > 0) tail--;
            @(negedge clk);
        end
        req_i = 1'b0;
        a2c = t_cmd - t_ale;
        gap = (t_ale2 >= 0) ? (t_ale2 - t_done) : -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int a2c, len, gap;
        logic ale_ok, strobe_ok, done_ok, tmo_seen;

        // R1: idle outputs during and after reset
        repeat (3) @(negedge clk);
        chk("R1 ale in reset", ale_o, 0);
        chk("R1 commands in reset", {rd_n_o, wr_n_o}, 3);
        chk("R1 done/tmo in reset", {done_o, tmo_err_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", {ale_o, rd_n_o, wr_n_o, done_o, tmo_err_o}, 5'b01100);

        // Table walk: R2 R3 R4 R5 R8 R9 R10 R11
        foreach (VECS[i]) begin
            cfg_ws_i = VECS[i].ws; cfg_cmd_dly_i = VECS[i].dly;
            cfg_async_i = VECS[i].asy; cfg_mux_i = VECS[i].mux;
            cfg_trail_i = VECS[i].trl; rdy_n_i = 1'b0;
            repeat (4) @(negedge clk);
            measure(VECS[i].wr, 0, -1, a2c, len, gap, ale_ok, strobe_ok, done_ok, tmo_seen);
            chk($sformatf("R5 vec%0d command length", i), len, int'(VECS[i].len));
            chk($sformatf("R3 vec%0d strobe to command", i), a2c, int'(VECS[i].a2c));
            chk($sformatf("R9 R10 vec%0d done to next strobe", i), gap, int'(VECS[i].gap));
            chk($sformatf("R2 vec%0d strobe shape", i), ale_ok, 1);
            chk($sformatf("R4 vec%0d strobe select", i), strobe_ok, 1);
            chk($sformatf("R8 vec%0d done pulse", i), done_ok, 1);
            chk($sformatf("R11 vec%0d no timeout", i), tmo_seen, 0);
        end

        // R10: request pulses landing inside the recovery gap (mux + trail)
        cfg_ws_i = 4'd1; cfg_cmd_dly_i = 1'b0; cfg_async_i = 1'b0;
        cfg_mux_i = 1'b1; cfg_trail_i = 1'b1; rdy_n_i = 1'b0;
        repeat (4) @(negedge clk);
        measure(1'b0, 1, -1, a2c, len, gap, ale_ok, strobe_ok, done_ok, tmo_seen);
        chk("R10 held request, first gap clock", gap, 3);
        repeat (4) @(negedge clk);
        measure(1'b1, 2, -1, a2c, len, gap, ale_ok, strobe_ok, done_ok, tmo_seen);
        chk("R10 request in last gap clock", gap, 3);
        cfg_mux_i = 1'b0; cfg_trail_i = 1'b0;

        // R6: synchronous READY stretch
        cfg_ws_i = 4'd1; cfg_async_i = 1'b0; rdy_n_i = 1'b1;
        repeat (4) @(negedge clk);
        measure(1'b0, -1, 2, a2c, len, gap, ale_ok, strobe_ok, done_ok, tmo_seen);
        chk("R6 sync READY j=2 ws=1", len, 4);
        chk("R8 stretched done pulse", done_ok, 1);
        cfg_ws_i = 4'd6; rdy_n_i = 1'b1;
        repeat (4) @(negedge clk);
        measure(1'b1, -1, 1, a2c, len, gap, ale_ok, strobe_ok, done_ok, tmo_seen);
        chk("R6 sync early READY ws=6", len, 7);

        // R7: asynchronous READY costs one more clock
        cfg_ws_i = 4'd1; cfg_async_i = 1'b1; rdy_n_i = 1'b1;
        repeat (4) @(negedge clk);
        measure(1'b0, -1, 2, a2c, len, gap, ale_ok, strobe_ok, done_ok, tmo_seen);
        chk("R7 async READY j=2 ws=1", len, 5);
        cfg_ws_i = 4'd0; rdy_n_i = 1'b1;
        repeat (4) @(negedge clk);
        measure(1'b1, -1, 0, a2c, len, gap, ale_ok, strobe_ok, done_ok, tmo_seen);
        chk("R7 async READY j=0 ws=0", len, 3);

        // R11: READY never arrives
        cfg_ws_i = 4'd2; cfg_async_i = 1'b0; rdy_n_i = 1'b1;
        repeat (4) @(negedge clk);
        measure(1'b0, -1, -1, a2c, len, gap, ale_ok, strobe_ok, done_ok, tmo_seen);
        chk("R11 timeout length", len, 258);
        chk("R11 timeout flag", tmo_seen, 1);
        rdy_n_i = 1'b0;
        repeat (4) @(negedge clk);

        // R12: clock-output enable
        cfg_async_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 async idle", clkout_en_o, 0);
        cfg_async_i = 1'b0;
        @(negedge clk);
        chk("R12 sync idle", clkout_en_o, 1);
        cfg_async_i = 1'b1;
        @(negedge clk);
        req_i = 1'b1; wr_i = 1'b0;
        @(negedge clk);
        req_i = 1'b0;
        chk("R12 async strobe clock", {ale_o, clkout_en_o}, 2'b11);
        repeat (10) @(negedge clk);
        chk("R12 async idle again", clkout_en_o, 0);

        finish_run();
    end

endmodule